// File: doc/BRIEF.md
# Three-Channel Down-Counter Timer with Watchdog Reset

This peripheral holds three 32-bit down-counters behind a simple register port of 32-bit words. Channel 0 serves as a periodic tick source. Channel 1 serves as a free-running timebase: with a reload of all ones it wraps forever, and software derives elapsed ticks as all-ones minus the count. Channel 2 is a watchdog. Each channel has a count register and a separate reload register. A shared control word holds one run bit and one auto-reload bit per channel.

Each expiry latches a bit in an event register. Software acknowledges an event by writing that register back with the bit at zero. An interrupt line rises for every latched event whose mask bit is set. An expiry of the watchdog channel also drives a one-cycle reset request, but only while a separate reset-request enable bit is set.

Top module: `tmr_wdog`

## Requirements
- R1: After reset, every count, reload, control, event, mask and reset-enable register reads zero, and `irq_o` and `rst_out_o` are low.
- R2: Register map (byte addresses):
  - count of channel n at 8n and its reload at 8n+4;
  - control at 0x20, events at 0x24, mask at 0x28, reset-request enable at 0x2C (bit 0);
  - any other address reads 0;
  - `rdata` presents the addressed register on the clock after a cycle with `rd_en` high;
  - control, event and mask bits above their width read as zero.
- R3: A channel whose run bit is set and whose count is not zero decrements by one every clock. A channel whose run bit is clear holds its count.
- R4: When a running channel's count is 1, the next clock is its expiry and sets event bit n. With auto-reload clear the count becomes 0 and stays there, and no further event occurs.
- R5: With auto-reload set, the expiry loads the reload value in place of 0. Counting continues, so the period is the reload value in clocks.
- R6: A write to a count register loads that value in the same clock. The write takes precedence over the decrement or expiry of that clock.
- R7: Writing the event register clears each bit written as 0 and keeps each bit written as 1. An expiry in the same clock as a clearing write leaves its bit set. No event bit falls without a write.
- R8: `irq_o` is high one clock after any event bit and its mask bit are both set, and low one clock after no such pair remains.
- R9: An expiry of channel 2 pulses `rst_out_o` for one clock, in the same clock that sets event bit 2. The pulse occurs only when the reset-request enable bit is set.
- R10: In the control word, bit 2n is the run bit of channel n and bit 2n+1 is its auto-reload bit. Each bit affects only its own channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request, masked events |
| rst_out_o | output | 1 | Watchdog reset request pulse |

## Verification
On every cycle, the embedded assertions check the following:
- a stopped counter keeps its value;
- a running counter steps down by exactly one;
- a one-shot expiry lands on zero;
- no event bit falls without a write;
- an expiry always leaves its event bit set;
- the reset request never appears without its enable.

Some behaviours can only be shown by the bench scenarios:
- the reload period;
- the precedence of a count write over counting;
- the exact clock at which an acknowledge races an expiry;
- the one-clock delay of the interrupt line;
- the count of reset pulses with the enable set and with it clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CTRL_OFF  = 32'h20;
  localparam int unsigned CAUSE_OFF = 32'h24;
  localparam int unsigned MASK_OFF  = 32'h28;
  localparam int unsigned RSTEN_OFF = 32'h2C;

  function automatic int unsigned cnt_off(int unsigned ch);
    return ch * 8;
  endfunction

  function automatic int unsigned rld_off(int unsigned ch);
    return ch * 8 + 4;
  endfunction
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          auto_rl,
  input  logic          cnt_we,
  input  logic          rld_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] rld_o,
  output logic          evt_o
);
  logic [DW-1:0] cnt_q, rld_q;
  logic          expire;

  assign expire = run && !cnt_we && (cnt_q == DW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      if (cnt_we)
        cnt_q <= wdata;
      else if (expire)
        cnt_q <= auto_rl ? rld_q : '0;
      else if (run && cnt_q != '0)
        cnt_q <= cnt_q - DW'(1);
      if (rld_we)
        rld_q <= wdata;
    end
  end

  assign cnt_o = cnt_q;
  assign rld_o = rld_q;
  assign evt_o = expire;

  // R3: stopped channel holds its count
  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_we) |=> $stable(cnt_q));
  // R3: running channel above one steps down by one
  p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !cnt_we && cnt_q > DW'(1)) |=> (cnt_q == $past(cnt_q) - DW'(1)));
  // R4: one-shot expiry lands on zero
  p_oneshot_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !auto_rl && !cnt_we && cnt_q == DW'(1)) |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int NCH   = 3,
  parameter int WD_CH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] evt,
  input  logic           cause_we,
  input  logic           mask_we,
  input  logic           rsten_we,
  input  logic [NCH-1:0] wbits,
  input  logic           wen_bit,
  output logic [NCH-1:0] cause_o,
  output logic [NCH-1:0] mask_o,
  output logic           rsten_o,
  output logic           irq_o,
  output logic           rst_out_o
);
  logic [NCH-1:0] cause_q, mask_q;
  logic           rsten_q, irq_q, rst_out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q   <= '0;
      mask_q    <= '0;
      rsten_q   <= 1'b0;
      irq_q     <= 1'b0;
      rst_out_q <= 1'b0;
    end else begin
      cause_q   <= (cause_we ? (cause_q & wbits) : cause_q) | evt;
      if (mask_we)  mask_q  <= wbits;
      if (rsten_we) rsten_q <= wen_bit;
      irq_q     <= |(cause_q & mask_q);
      rst_out_q <= evt[WD_CH] & rsten_q;
    end
  end

  assign cause_o   = cause_q;
  assign mask_o    = mask_q;
  assign rsten_o   = rsten_q;
  assign irq_o     = irq_q;
  assign rst_out_o = rst_out_q;

  // R7: no event bit falls without a write
  p_cause_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !cause_we |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
  // R7: an expiry always leaves its bit set, even against a clearing write
  p_evt_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((cause_q & $past(evt)) == $past(evt)));
  // R9: reset request only with its enable
  p_rstout_gated_r9: assert property (@(posedge clk) disable iff (rst)
    rst_out_o |-> $past(rsten_q));
  // R8: no masked event for two clocks means no interrupt
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    ($past((cause_q & mask_q) == '0) && $past(!irq_q)) |-> !irq_o);
endmodule

// File: rtl/tmr_wdog.sv
module tmr_wdog #(
  parameter int NUM_CH = 3,
  parameter int DW     = 32,
  parameter int AW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq_o,
  output logic          rst_out_o
);
  import tmr_pkg::*;

  localparam int CW    = 2 * NUM_CH;
  localparam int WD_CH = NUM_CH - 1;

  logic [CW-1:0]     ctrl_q;
  logic [NUM_CH-1:0] evt, cause, mask;
  logic              rsten;
  logic [DW-1:0]     cnt [NUM_CH];
  logic [DW-1:0]     rld [NUM_CH];
  logic [DW-1:0]     rd_mux;
  logic [31:0]       a32;

  assign a32 = 32'(addr);

  always_ff @(posedge clk) begin
    if (rst)
      ctrl_q <= '0;
    else if (wr_en && a32 == CTRL_OFF)
      ctrl_q <= wdata[CW-1:0];
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tmr_chan #(.DW(DW)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .run     (ctrl_q[2*i]),
      .auto_rl (ctrl_q[2*i+1]),
      .cnt_we  (wr_en && a32 == cnt_off(i)),
      .rld_we  (wr_en && a32 == rld_off(i)),
      .wdata   (wdata),
      .cnt_o   (cnt[i]),
      .rld_o   (rld[i]),
      .evt_o   (evt[i])
    );
  end

  tmr_irq #(.NCH(NUM_CH), .WD_CH(WD_CH)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .evt       (evt),
    .cause_we  (wr_en && a32 == CAUSE_OFF),
    .mask_we   (wr_en && a32 == MASK_OFF),
    .rsten_we  (wr_en && a32 == RSTEN_OFF),
    .wbits     (wdata[NUM_CH-1:0]),
    .wen_bit   (wdata[0]),
    .cause_o   (cause),
    .mask_o    (mask),
    .rsten_o   (rsten),
    .irq_o     (irq_o),
    .rst_out_o (rst_out_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (a32 == cnt_off(i)) rd_mux = cnt[i];
      if (a32 == rld_off(i)) rd_mux = rld[i];
    end
    if (a32 == CTRL_OFF)  rd_mux = DW'(ctrl_q);
    if (a32 == CAUSE_OFF) rd_mux = DW'(cause);
    if (a32 == MASK_OFF)  rd_mux = DW'(mask);
    if (a32 == RSTEN_OFF) rd_mux = DW'(rsten);
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_mux;
  end

  // R1: outputs quiet in the clock after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && !rst_out_o && rdata == '0));
endmodule

// File: tb/test_tmr_wdog.sv
module test_tmr_wdog;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, rst_out_o;

  tmr_wdog i_tmr_wdog (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .rst_out_o(rst_out_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int          checks = 0, errors = 0, rst_pulses = 0;
  logic        rd_q = 1'b0;
  logic        done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(posedge clk) rd_q <= rd_en;

  // monitor: pops expected reads and compares them
  always @(negedge clk) begin
    if (rd_q) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: read %h expected %h", t, rdata, e);
      end
    end
    if (rst_out_o) rst_pulses++;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({31'd0, irq_o}, 0, "R1 irq after reset");
    chk({31'd0, rst_out_o}, 0, "R1 rst_out after reset");
    for (int a = 0; a <= 'h2C; a += 4) rd(8'(a), 0, "R1 register zero");
    rd(8'h30, 0, "R2 unmapped address");

    // R2 map readback
    wr(8'h00, 32'd5); wr(8'h04, 32'd7); wr(8'h14, 32'hA5A5_0001);
    rd(8'h00, 5, "R2 count ch0"); rd(8'h04, 7, "R2 reload ch0");
    rd(8'h14, 32'hA5A5_0001, "R2 reload ch2");

    // R3 decrement and hold, R10 bit 2 runs ch1 only
    wr(8'h08, 32'd100); wr(8'h00, 32'd55);
    wr(8'h20, 32'h4); repeat (8) @(negedge clk); wr(8'h20, 0);
    rd(8'h08, 90, "R3 ch1 decrement");
    rd(8'h00, 55, "R10 ch0 unaffected by ch1 run bit");
    rd(8'h08, 90, "R3 stopped channel holds");

    // R6 count write overrides counting
    wr(8'h08, 32'd200); wr(8'h20, 32'h4); repeat (3) @(negedge clk);
    wr(8'h08, 32'd50); wr(8'h20, 0);
    rd(8'h08, 48, "R6 write overrides count");

    // R4 one-shot expiry, R8 mask
    wr(8'h00, 32'd3); wr(8'h20, 32'h1); repeat (10) @(negedge clk); wr(8'h20, 0);
    rd(8'h00, 0, "R4 one-shot stops at zero");
    rd(8'h24, 1, "R4 event bit set");
    chk({31'd0, irq_o}, 0, "R8 irq low while masked");
    wr(8'h28, 32'h1);
    chk({31'd0, irq_o}, 0, "R8 irq delayed one clock");
    @(negedge clk);
    chk({31'd0, irq_o}, 1, "R8 irq after mask");
    // R7 write-one keeps, write-zero clears
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, 1, "R7 write one keeps bit");
    wr(8'h24, 32'hFFFF_FFFE);
    @(negedge clk);
    chk({31'd0, irq_o}, 0, "R8 irq falls after clear");
    rd(8'h24, 0, "R7 write zero clears");

    // R7 expiry races a clearing write
    wr(8'h00, 32'd3); wr(8'h20, 32'h1); repeat (1) @(negedge clk);
    wr(8'h24, 0); wr(8'h20, 0);
    rd(8'h24, 1, "R7 hardware set wins");
    wr(8'h24, 0); wr(8'h28, 0);

    // R5 auto-reload period 4
    wr(8'h04, 32'd4); wr(8'h00, 32'd2); wr(8'h20, 32'h3);
    repeat (9) @(negedge clk); wr(8'h20, 0);
    rd(8'h00, 3, "R5 periodic reload");
    rd(8'h24, 1, "R5 event on reload");
    rd(8'h04, 4, "R5 reload kept");
    wr(8'h24, 0);

    // R9 watchdog without enable
    rst_pulses = 0;
    wr(8'h10, 32'd3); wr(8'h20, 32'h10); repeat (6) @(negedge clk);
    chk(rst_pulses, 0, "R9 no reset request when disabled");
    rd(8'h24, 4, "R9 watchdog event bit");
    wr(8'h24, 0); wr(8'h2C, 1);
    rd(8'h2C, 1, "R2 reset enable readback");
    wr(8'h10, 32'd3); repeat (6) @(negedge clk);
    chk(rst_pulses, 1, "R9 single reset pulse");
    rd(8'h24, 4, "R9 event with pulse");
    rd(8'h00, 3, "R10 ch0 unaffected by ch2 run bit");
    wr(8'h20, 0);

    // R2 width of narrow registers
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h28, 32'h7, "R2 mask width");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule